// File: doc/BRIEF.md
# Partial Address Load Disambiguation Unit

This unit sits beside a centralised load/store queue. It decides when each load may start its cache access when memory addresses arrive in two pieces. The low-order piece of every load and store address arrives first as a narrow early packet. That packet carries the queue tag, the cache set index (the low address bits) and the TLB index. The high-order piece arrives later, together with its queue tag.

A load is compared against every older store in the queue as soon as the low bits of the load and of all those stores are known. If the load's low bits differ from every one of them, it is released to the cache at once, and the cache and TLB arrays can be read from the early index bits. If the low bits match, the load is held until the high bits settle the case. When the high bits differ, the load is released. When they are equal, the dependence is real and the load waits until the store leaves the queue.

Entries are allocated in program order through a valid/ready port that back-pressures when the queue is full. Early and late address pieces are always accepted and carry no ready signal. Released loads leave through a valid/ready port. The issue output stays valid while `iss_ready` is low, but the packet it shows may change to an older load that has just become eligible. Retirement is plain control: the head entry leaves when `ret_valid` and `ret_ready` are both high.

Top module: `pald_unit`

## Requirements
- R1: After reset the queue is empty: `alloc_ready`=1, `iss_valid`=0, `ret_ready`=0, `viol`=0.
- R2: `alloc_tag` shows the slot the next allocation takes. Slots are handed out in rising order and wrap modulo DEPTH, with the upper tag bits zero. `alloc_ready` is 0 while DEPTH entries are held.
- R3: The early packet holds the tag in its top TAG_W bits, the cache set index (the low LO_W address bits) in the next LO_W bits, and the TLB index in the bottom TLB_W bits. `iss_pkt` uses the same layout with the issued load's tag, set and TLB index.
- R4: A load is not eligible until its own early piece and the early piece of every older store in the queue have arrived.
- R5: A load whose low bits differ from those of every older store becomes eligible without waiting for any high piece.
- R6: A load whose low bits equal those of an older store stays held until both high pieces are known. It becomes eligible if the high pieces differ.
- R7: A load whose full address equals that of an older store stays held until that store retires.
- R8: Among eligible loads, the oldest in program order is offered first, one per cycle. `iss_valid` stays high while `iss_ready` is low.
- R9: `ret_ready` is high only when the head entry is complete: a store with both pieces known, or a load that has issued.
- R10: `viol` goes high when an issued load and an older store, both with full addresses known, are equal. Under the release rules above it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Queue has a free slot |
| alloc_store | input | 1 | 1 = store entry, 0 = load entry |
| alloc_tag | output | TAG_W | Tag of the slot the next allocation takes |
| early_valid | input | 1 | Early packet present (always accepted) |
| early_pkt | input | TAG_W+LO_W+TLB_W | Tag, set index and TLB index |
| late_valid | input | 1 | High address piece present (always accepted) |
| late_tag | input | TAG_W | Entry the high piece belongs to |
| late_hi | input | HI_W | High-order address bits |
| iss_valid | output | 1 | A load is offered to the cache |
| iss_ready | input | 1 | Cache accepts the offered load |
| iss_pkt | output | TAG_W+LO_W+TLB_W | Packed tag, set index and TLB index of the offered load |
| ret_valid | input | 1 | Request to retire the head entry |
| ret_ready | output | 1 | Head entry may retire |
| viol | output | 1 | Issued load fully matches an older store |

## Verification
The bench builds the unit with DEPTH=4, LO_W=2, HI_W=2 and TLB_W=2. With these values every pair of store address and load address (256 pairs) can be swept. Each of the three outcomes is therefore reached many times: release on a low-bit mismatch, release after the high bits differ, and a hold until the store retires. The shallow queue also makes the full back-pressure, the tag wrap-around and the oldest-first choice among several waiting loads easy to reach.

// File: rtl/pald_pkg.sv
`timescale 1ns/1ps
package pald_pkg;
  typedef enum logic {
    K_LOAD  = 1'b0,
    K_STORE = 1'b1
  } kind_e;
endpackage

// File: rtl/pald_pkt_codec.sv
`timescale 1ns/1ps
// Splits an incoming early packet into its fields and assembles an outgoing one.
module pald_pkt_codec #(
  parameter int TAG_W = 6,
  parameter int LO_W  = 8,
  parameter int TLB_W = 4,
  localparam int PKT_W = TAG_W + LO_W + TLB_W
) (
  input  logic [PKT_W-1:0] rx_pkt,
  output logic [TAG_W-1:0] rx_tag,
  output logic [LO_W-1:0]  rx_set,
  output logic [TLB_W-1:0] rx_tlb,
  input  logic [TAG_W-1:0] tx_tag,
  input  logic [LO_W-1:0]  tx_set,
  input  logic [TLB_W-1:0] tx_tlb,
  output logic [PKT_W-1:0] tx_pkt
);
  assign rx_tag = rx_pkt[PKT_W-1 -: TAG_W];
  assign rx_set = rx_pkt[TLB_W +: LO_W];
  assign rx_tlb = rx_pkt[TLB_W-1:0];
  assign tx_pkt = {tx_tag, tx_set, tx_tlb};
endmodule

// File: rtl/pald_dep_check.sv
`timescale 1ns/1ps
// Per-entry release decision against all older stores, plus violation detection.
module pald_dep_check #(
  parameter int DEPTH = 16,
  parameter int LO_W  = 8,
  parameter int HI_W  = 24,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]           vld,
  input  logic [DEPTH-1:0]           is_st,
  input  logic [DEPTH-1:0]           lo_ok,
  input  logic [DEPTH-1:0]           hi_ok,
  input  logic [DEPTH-1:0]           done,
  input  logic [DEPTH-1:0][LO_W-1:0] lo,
  input  logic [DEPTH-1:0][HI_W-1:0] hi,
  input  logic [PTR_W-1:0]           head,
  output logic [DEPTH-1:0]           rdy,
  output logic [DEPTH-1:0]           bad
);
  function automatic logic [PTR_W-1:0] age_of(input int slot, input logic [PTR_W-1:0] h);
    return PTR_W'(slot) - h;
  endfunction

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      rdy[i] = vld[i] & ~is_st[i] & lo_ok[i] & ~done[i];
      bad[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (vld[j] && is_st[j] && (age_of(j, head) < age_of(i, head))) begin
          if (!lo_ok[j]) begin
            rdy[i] = 1'b0;
          end else if (lo[j] == lo[i]) begin
            if (!(hi_ok[i] && hi_ok[j] && (hi[j] != hi[i]))) rdy[i] = 1'b0;
            if (vld[i] && !is_st[i] && done[i] && lo_ok[i] && hi_ok[i] && hi_ok[j]
                && (hi[j] == hi[i]))
              bad[i] = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pald_pick.sv
`timescale 1ns/1ps
// Oldest-first selection among eligible entries, scanning from the queue head.
module pald_pick #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req,
  input  logic [PTR_W-1:0] head,
  output logic [DEPTH-1:0] gnt,
  output logic [PTR_W-1:0] idx,
  output logic             any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (!any && req[head + PTR_W'(k)]) begin
        any = 1'b1;
        idx = head + PTR_W'(k);
        gnt[head + PTR_W'(k)] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pald_unit.sv
`timescale 1ns/1ps
module pald_unit #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 6,
  parameter int LO_W  = 8,
  parameter int TLB_W = 4,
  parameter int HI_W  = 24,
  localparam int PKT_W = TAG_W + LO_W + TLB_W,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  output logic             alloc_ready,
  input  logic             alloc_store,
  output logic [TAG_W-1:0] alloc_tag,
  input  logic             early_valid,
  input  logic [PKT_W-1:0] early_pkt,
  input  logic             late_valid,
  input  logic [TAG_W-1:0] late_tag,
  input  logic [HI_W-1:0]  late_hi,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic [PKT_W-1:0] iss_pkt,
  input  logic             ret_valid,
  output logic             ret_ready,
  output logic             viol
);
  import pald_pkg::*;

  logic [DEPTH-1:0]            vld, is_st, lo_ok, hi_ok, done;
  logic [DEPTH-1:0][LO_W-1:0]  lo_q;
  logic [DEPTH-1:0][HI_W-1:0]  hi_q;
  logic [DEPTH-1:0][TLB_W-1:0] tlb_q;
  logic [PTR_W-1:0]            head, tail;
  logic [CNT_W-1:0]            count;

  logic [TAG_W-1:0] e_tag;
  logic [LO_W-1:0]  e_set;
  logic [TLB_W-1:0] e_tlb;
  logic [DEPTH-1:0] rdy, bad, gnt;
  logic [PTR_W-1:0] pick_idx;
  logic             pick_any;
  logic             alloc_fire, iss_fire, ret_fire;
  logic [PTR_W-1:0] e_slot, l_slot;
  kind_e            new_kind;

  pald_pkt_codec #(.TAG_W(TAG_W), .LO_W(LO_W), .TLB_W(TLB_W)) u_codec (
    .rx_pkt(early_pkt), .rx_tag(e_tag), .rx_set(e_set), .rx_tlb(e_tlb),
    .tx_tag(TAG_W'(pick_idx)), .tx_set(lo_q[pick_idx]), .tx_tlb(tlb_q[pick_idx]),
    .tx_pkt(iss_pkt)
  );

  pald_dep_check #(.DEPTH(DEPTH), .LO_W(LO_W), .HI_W(HI_W)) u_dep (
    .vld(vld), .is_st(is_st), .lo_ok(lo_ok), .hi_ok(hi_ok), .done(done),
    .lo(lo_q), .hi(hi_q), .head(head), .rdy(rdy), .bad(bad)
  );

  pald_pick #(.DEPTH(DEPTH)) u_pick (
    .req(rdy), .head(head), .gnt(gnt), .idx(pick_idx), .any(pick_any)
  );

  assign new_kind    = alloc_store ? K_STORE : K_LOAD;
  assign alloc_ready = (count != CNT_W'(DEPTH));
  assign alloc_tag   = TAG_W'(tail);
  assign alloc_fire  = alloc_valid & alloc_ready;
  assign iss_valid   = pick_any;
  assign iss_fire    = iss_valid & iss_ready;
  assign ret_ready   = vld[head] & (is_st[head] ? (lo_ok[head] & hi_ok[head]) : done[head]);
  assign ret_fire    = ret_valid & ret_ready;
  assign viol        = |bad;
  assign e_slot      = e_tag[PTR_W-1:0];
  assign l_slot      = late_tag[PTR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; is_st <= '0; lo_ok <= '0; hi_ok <= '0; done <= '0;
      lo_q <= '0; hi_q <= '0; tlb_q <= '0;
      head <= '0; tail <= '0; count <= '0;
    end else begin
      if (early_valid) begin
        lo_q[e_slot]  <= e_set;
        tlb_q[e_slot] <= e_tlb;
        lo_ok[e_slot] <= 1'b1;
      end
      if (late_valid) begin
        hi_q[l_slot]  <= late_hi;
        hi_ok[l_slot] <= 1'b1;
      end
      if (iss_fire) done[pick_idx] <= 1'b1;
      if (ret_fire) begin
        vld[head] <= 1'b0;
        head      <= head + 1'b1;
      end
      if (alloc_fire) begin
        vld[tail]   <= 1'b1;
        is_st[tail] <= (new_kind == K_STORE);
        lo_ok[tail] <= 1'b0;
        hi_ok[tail] <= 1'b0;
        done[tail]  <= 1'b0;
        tail        <= tail + 1'b1;
      end
      count <= count + CNT_W'(alloc_fire) - CNT_W'(ret_fire);
    end
  end

  // R8: an offered load is not withdrawn while the cache stalls
  p_hold_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |=> iss_valid);
  // R8: at most one load granted per cycle
  p_one_grant_r8: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  // R4: the offered load has its low bits
  p_lo_known_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> lo_ok[pick_idx]);
  // R2: an allocation without retirement grows occupancy by one
  p_alloc_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire && !ret_fire |=> count == $past(count) + 1'b1);
  // R9: the retired head slot is freed
  p_ret_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |=> !vld[$past(head)]);
  // R10: no true dependence is ever bypassed
  p_no_viol_r10: assert property (@(posedge clk) disable iff (!rst_n) !viol);
endmodule

// File: tb/pald_unit_tb.sv
`timescale 1ns/1ps
module pald_unit_tb;
  localparam int DEPTH = 4, TAG_W = 6, LO_W = 2, TLB_W = 2, HI_W = 2;
  localparam int PKT_W = TAG_W + LO_W + TLB_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, alloc_ready, alloc_store = 0;
  logic [TAG_W-1:0] alloc_tag;
  logic early_valid = 0, late_valid = 0, iss_valid, iss_ready = 0;
  logic ret_valid = 0, ret_ready, viol;
  logic [PKT_W-1:0] early_pkt = '0, iss_pkt;
  logic [TAG_W-1:0] late_tag = '0;
  logic [HI_W-1:0] late_hi = '0;
  int total = 0, bad = 0, nxt = 0;

  always #2.5 clk = ~clk;

  pald_unit #(.DEPTH(DEPTH), .TAG_W(TAG_W), .LO_W(LO_W), .TLB_W(TLB_W), .HI_W(HI_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_store(alloc_store), .alloc_tag(alloc_tag), .early_valid(early_valid),
    .early_pkt(early_pkt), .late_valid(late_valid), .late_tag(late_tag), .late_hi(late_hi),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_pkt(iss_pkt),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .viol(viol));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input int act, input int exp, input string req, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_alloc(input bit st, output int tag);
    chk(alloc_tag, nxt, "R2", "alloc_tag");
    tag = nxt;
    nxt = (nxt + 1) % DEPTH;
    alloc_store = st; alloc_valid = 1; tick(); alloc_valid = 0;
  endtask

  task automatic send_early(input int tag, input int lo, input int tlb);
    early_pkt = PKT_W'((tag << (LO_W + TLB_W)) | (lo << TLB_W) | tlb);
    early_valid = 1; tick(); early_valid = 0;
  endtask

  task automatic send_late(input int tag, input int hi);
    late_tag = TAG_W'(tag); late_hi = HI_W'(hi);
    late_valid = 1; tick(); late_valid = 0;
  endtask

  task automatic take_issue(input int tag, input int lo, input int tlb, input string req);
    chk(iss_valid, 1, req, "iss_valid");
    chk(iss_pkt, (tag << (LO_W + TLB_W)) | (lo << TLB_W) | tlb, "R3", "iss_pkt");
    iss_ready = 1; tick(); iss_ready = 0;
  endtask

  task automatic do_retire();
    chk(ret_ready, 1, "R9", "ret_ready");
    ret_valid = 1; tick(); ret_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ts, tl, t0, t1, t2, t3;
    tick(); tick(); rst_n = 1; tick();
    // R1 reset state
    chk(alloc_ready, 1, "R1", "alloc_ready"); chk(iss_valid, 0, "R1", "iss_valid");
    chk(ret_ready, 0, "R1", "ret_ready");     chk(viol, 0, "R1", "viol");

    // Sweep every store/load address pair
    for (int sa = 0; sa < 16; sa++) begin
      for (int la = 0; la < 16; la++) begin
        int slo, shi, llo, lhi, ltlb;
        slo = sa % 4; shi = sa / 4; llo = la % 4; lhi = la / 4; ltlb = (sa + la) % 4;
        do_alloc(1, ts); do_alloc(0, tl);
        send_early(tl, llo, ltlb);
        chk(iss_valid, 0, "R4", "held until older store low bits");
        send_early(ts, slo, 1);
        chk(ret_ready, 0, "R9", "store head without high part");
        if (llo != slo) begin
          take_issue(tl, llo, ltlb, "R5");
          send_late(tl, lhi); send_late(ts, shi);
        end else begin
          chk(iss_valid, 0, "R6", "low match holds");
          send_late(tl, lhi);
          chk(iss_valid, 0, "R6", "store high unknown");
          send_late(ts, shi);
          if (lhi != shi) begin
            take_issue(tl, llo, ltlb, "R6");
          end else begin
            chk(iss_valid, 0, "R7", "true match holds");
            chk(ret_ready, 1, "R9", "complete store");
            ret_valid = 1; tick(); ret_valid = 0;
            take_issue(tl, llo, ltlb, "R7");
            chk(viol, 0, "R10", "viol");
            do_retire();
            continue;
          end
        end
        chk(viol, 0, "R10", "viol");
        do_retire(); do_retire();
      end
    end

    // Oldest-first selection, back-pressure, full queue
    do_alloc(0, t0); do_alloc(0, t1); do_alloc(0, t2); do_alloc(1, t3);
    chk(alloc_ready, 0, "R2", "full");
    chk(ret_ready, 0, "R9", "unissued load head");
    send_early(t2, 3, 2);
    chk(iss_pkt >> (LO_W + TLB_W), t2, "R8", "only ready load");
    send_early(t1, 1, 0);
    chk(iss_pkt >> (LO_W + TLB_W), t1, "R8", "older load first");
    tick(); tick();
    chk(iss_valid, 1, "R8", "valid held under stall");
    take_issue(t1, 1, 0, "R8");
    take_issue(t2, 3, 2, "R8");
    chk(iss_valid, 0, "R8", "one per cycle drained");
    send_early(t0, 0, 1);
    take_issue(t0, 0, 1, "R8");
    do_retire(); do_retire(); do_retire();
    chk(alloc_ready, 1, "R2", "space after retire");
    send_early(t3, 2, 0); send_late(t3, 1);
    do_retire();
    chk(ret_ready, 0, "R9", "empty");
    chk(viol, 0, "R10", "viol end");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule